// File: doc/BRIEF.md
# Queue-Driven Bandwidth Level Controller

This block picks the operating bandwidth of an adaptive-rate multicarrier transmitter from the fill level of its transmit queue. The bandwidth is one of a small set of power-of-two levels. The lowest level uses one processing lane, and each level above it doubles the lane count, up to the full lane set. A lane-enable mask leaves the unused parallel lanes free to be power-gated.

The block counts frame-start strobes in windows of a configured length. At the frame start that closes each window, it compares the current queue byte count with a low and a high threshold. A short queue moves the level one step down. A long queue moves it one step up. Otherwise the level holds. When the level changes, a one-cycle strobe carries the new level so that it can be inserted into the control subcarrier. The level and the lane mask switch at the next frame start, so the far end always hears about a change one frame before it takes effect.

Top module: `bw_level_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, `bw_level` reads the full level (2 with four lanes), `lane_en` has every lane set, and `chg_stb` is 0.
- R2: A decision is taken only at a frame start, and only at every W-th frame start counted from reset, where W is `win_frames`. A `win_frames` value of 0 or 1 acts as 2.
- R3: At a decision, if `q_len` < `th_lo` and the level is above 0, the next level is the current level minus one.
- R4: At a decision, if `q_len` > `th_hi` and the level is below full, the next level is the current level plus one. This rule takes priority over R3 when both conditions hold.
- R5: At a decision, the level holds if neither R3 nor R4 applies. This covers a queue equal to either threshold, a short queue at level 0, and a long queue at full level.
- R6: `chg_stb` is high for exactly the one cycle that follows a decision frame start whose next level differs from the current one. In that cycle `chg_level` shows the new level, and it keeps that value until the next announcement.
- R7: An announced level is applied to `bw_level` and `lane_en` at the next frame start, never earlier. Each change moves the level by exactly one step.
- R8: Level encoding: 0 is quarter rate, 1 is half rate and 2 is full rate. Lane i of `lane_en` is set exactly when i < 2^level, so the masks are 0001, 0011 and 1111.
- R9: `q_len` has no effect in cycles that are not decision frame starts. Neither the level nor the strobe responds to it there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| q_len | input | QW (20) | Transmit queue length in bytes |
| th_lo | input | QW (20) | Queue length below which bandwidth is halved |
| th_hi | input | QW (20) | Queue length above which bandwidth is doubled |
| win_frames | input | WW (8) | Decision window length in frames |
| bw_level | output | LVLW (2) | Current bandwidth level |
| lane_en | output | NLANES (4) | Lane enable mask |
| chg_stb | output | 1 | One-cycle pulse announcing a level change |
| chg_level | output | LVLW (2) | Most recently announced level |

## Verification
The hardest case to bring about is an announced change that is still waiting for its commit frame. During that wait, the queue input is still moving, and the next window is only two frames away. The stimulus sets short windows, including the values 0 and 1 that act as 2, and spaces frame starts irregularly. Between frame starts it drives junk queue values, so that any sampling outside a decision edge or any early commit shows up at the ports. Directed sequences walk the level all the way to both limits and hold it there, and they put queue values exactly on the thresholds.

// File: rtl/bwc_pkg.sv
// Shared types for the bandwidth level controller.
package bwc_pkg;
    // Outcome of one window decision.
    typedef enum logic [1:0] {
        DEC_HOLD = 2'd0,
        DEC_DOWN = 2'd1,
        DEC_UP   = 2'd2
    } dec_e;
endpackage

// File: rtl/bwc_window.sv
// Decision window counter.
// Counts frame-start strobes and raises `decide` combinationally on the
// frame start that closes each window of W frames. W below 2 is raised to 2,
// so that a committed change never coincides with the next decision.
// Assumes frame_start is a single-cycle pulse.
module bwc_window #(
    parameter int WW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [WW-1:0] win_frames,
    output logic          decide
);
    localparam logic [WW-1:0] MIN_W = WW'(2);

    logic [WW-1:0] cnt_q;
    logic [WW-1:0] w_eff;
    logic          last;

    // Clamp the configured window to its legal minimum.
    always_comb w_eff = (win_frames < MIN_W) ? MIN_W : win_frames;

    // The last frame of a window; >= keeps a shrunk window from overrunning.
    always_comb last = (cnt_q >= (w_eff - WW'(1)));

    assign decide = frame_start && last;

    // Advance the frame counter on every frame start and wrap at the window end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (frame_start) begin
            cnt_q <= last ? '0 : cnt_q + WW'(1);
        end
    end
endmodule

// File: rtl/bwc_decide.sv
// Next-level decision logic (purely combinational).
// Compares the queue length with both thresholds and steps the level by one
// within [0, MAXLVL]. Stepping up takes priority over stepping down.
module bwc_decide
    import bwc_pkg::*;
#(
    parameter int QW   = 20,
    parameter int LVLW = 2,
    parameter int NLEVELS = 3
) (
    input  logic [QW-1:0]   q_len,
    input  logic [QW-1:0]   th_lo,
    input  logic [QW-1:0]   th_hi,
    input  logic [LVLW-1:0] cur_lvl,
    output dec_e            dec,
    output logic [LVLW-1:0] nxt_lvl
);
    localparam logic [LVLW-1:0] MAXLVL = LVLW'(NLEVELS - 1);

    logic can_up;
    logic can_down;

    // Test each threshold against the limits of the level range.
    always_comb begin
        can_up   = (q_len > th_hi) && (cur_lvl < MAXLVL);
        can_down = (q_len < th_lo) && (cur_lvl != '0);
    end

    // Choose the step, giving the upward direction priority.
    always_comb begin
        if (can_up) begin
            dec     = DEC_UP;
            nxt_lvl = cur_lvl + LVLW'(1);
        end else if (can_down) begin
            dec     = DEC_DOWN;
            nxt_lvl = cur_lvl - LVLW'(1);
        end else begin
            dec     = DEC_HOLD;
            nxt_lvl = cur_lvl;
        end
    end
endmodule

// File: rtl/bwc_lanes.sv
// Lane enable decoder.
// Level L enables the lowest 2^L lanes. Assumes NLANES is a power of two.
module bwc_lanes #(
    parameter int NLANES = 4,
    parameter int LVLW   = 2
) (
    input  logic [LVLW-1:0]   lvl,
    output logic [NLANES-1:0] lane_en
);
    localparam int SW = $clog2(NLANES) + 2;

    logic [SW-1:0] span;

    // Number of active lanes at this level.
    always_comb span = SW'(1) << lvl;

    // Per-lane compare against the active span.
    for (genvar i = 0; i < NLANES; i++) begin : g_lane
        localparam logic [SW-1:0] IDX = SW'(i);
        assign lane_en[i] = (IDX < span);
    end
endmodule

// File: rtl/bw_level_ctrl.sv
// Queue-driven bandwidth level controller (top).
// On each window-closing frame start it decides a new level from the queue
// length. A change is announced on chg_stb/chg_level in the next cycle, and it
// is applied to bw_level/lane_en at the following frame start.
// Assumes frame_start pulses for one cycle and frames last two or more cycles.
module bw_level_ctrl
    import bwc_pkg::*;
#(
    parameter int QW     = 20,
    parameter int WW     = 8,
    parameter int NLANES = 4,
    parameter int NLEVELS = $clog2(NLANES) + 1,
    parameter int LVLW   = (NLEVELS > 1) ? $clog2(NLEVELS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [QW-1:0]     q_len,
    input  logic [QW-1:0]     th_lo,
    input  logic [QW-1:0]     th_hi,
    input  logic [WW-1:0]     win_frames,
    output logic [LVLW-1:0]   bw_level,
    output logic [NLANES-1:0] lane_en,
    output logic              chg_stb,
    output logic [LVLW-1:0]   chg_level
);
    localparam logic [LVLW-1:0] MAXLVL = LVLW'(NLEVELS - 1);

    logic            decide;
    dec_e            dec;
    logic [LVLW-1:0] nxt_lvl;
    logic [LVLW-1:0] lvl_q;
    logic [LVLW-1:0] ann_q;
    logic            pend_q;
    logic            stb_q;

    bwc_window #(.WW(WW)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .win_frames  (win_frames),
        .decide      (decide)
    );

    bwc_decide #(.QW(QW), .LVLW(LVLW), .NLEVELS(NLEVELS)) u_dec (
        .q_len   (q_len),
        .th_lo   (th_lo),
        .th_hi   (th_hi),
        .cur_lvl (lvl_q),
        .dec     (dec),
        .nxt_lvl (nxt_lvl)
    );

    bwc_lanes #(.NLANES(NLANES), .LVLW(LVLW)) u_lanes (
        .lvl     (lvl_q),
        .lane_en (lane_en)
    );

    // Announce a decided change, then commit it at the next frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q  <= MAXLVL;
            ann_q  <= MAXLVL;
            pend_q <= 1'b0;
            stb_q  <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (frame_start && pend_q) begin
                lvl_q  <= ann_q;
                pend_q <= 1'b0;
            end
            if (decide && (dec != DEC_HOLD)) begin
                ann_q  <= nxt_lvl;
                pend_q <= 1'b1;
                stb_q  <= 1'b1;
            end
        end
    end

    assign bw_level  = lvl_q;
    assign chg_stb   = stb_q;
    assign chg_level = ann_q;
endmodule

// File: rtl/bwc_checker.sv
// Property checker for bw_level_ctrl, attached by bind below.
module bwc_checker #(
    parameter int NLANES = 4,
    parameter int LVLW   = 2,
    parameter int NLEVELS = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frame_start,
    input logic [LVLW-1:0]   bw_level,
    input logic [NLANES-1:0] lane_en,
    input logic              chg_stb,
    input logic [LVLW-1:0]   chg_level
);
    localparam int SW = $clog2(NLANES) + 2;

    AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bw_level) < NLEVELS);                                              // R8
    AST_LANE0_ON: assert property (@(posedge clk) disable iff (!rst_n)
        lane_en[0]);                                                            // R8
    AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lane_en) == (SW'(1) << bw_level));                           // R8
    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stb |=> !chg_stb);                                                  // R6
    AST_STB_NEW_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        chg_stb |-> (chg_level != bw_level));                                   // R6
    AST_CHANGE_AT_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_level != $past(bw_level)) |-> $past(frame_start));                  // R7
    AST_CHANGE_ANNOUNCED: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_level != $past(bw_level)) |-> (bw_level == $past(chg_level)));      // R7
    AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_level != $past(bw_level)) |->
            ((bw_level == $past(bw_level) + LVLW'(1)) ||
             (bw_level + LVLW'(1) == $past(bw_level))));                        // R7
endmodule

bind bw_level_ctrl bwc_checker #(
    .NLANES  (NLANES),
    .LVLW    (LVLW),
    .NLEVELS (NLEVELS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .bw_level    (bw_level),
    .lane_en     (lane_en),
    .chg_stb     (chg_stb),
    .chg_level   (chg_level)
);

// File: tb/sim_bw_level_ctrl.sv
`timescale 1ns/1ps
module sim_bw_level_ctrl;
    localparam int QW = 20;
    localparam int WW = 8;
    localparam int NL = 4;
    localparam int MAXL = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [QW-1:0] q_len = '0;
    logic [QW-1:0] th_lo = QW'(2500);
    logic [QW-1:0] th_hi = QW'(15000);
    logic [WW-1:0] win_frames = WW'(3);
    logic [1:0]    bw_level;
    logic [NL-1:0] lane_en;
    logic          chg_stb;
    logic [1:0]    chg_level;

    int n_run = 0;
    int n_fail = 0;

    // Reference model state.
    int m_lvl, m_ann, m_cnt;
    bit m_pend, m_stb;

    always #5 clk = ~clk;

    bw_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .q_len(q_len),
        .th_lo(th_lo), .th_hi(th_hi), .win_frames(win_frames),
        .bw_level(bw_level), .lane_en(lane_en), .chg_stb(chg_stb),
        .chg_level(chg_level)
    );

    function automatic int f_next(int lvl, int q, int lo, int hi);
        if (q > hi && lvl < MAXL) return lvl + 1;
        if (q < lo && lvl > 0) return lvl - 1;
        return lvl;
    endfunction

    function automatic int f_mask(int lvl);
        return (1 << (1 << lvl)) - 1;
    endfunction

    function automatic int f_weff(int w);
        return (w < 2) ? 2 : w;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check the current level, mask and strobe against the model.
    task automatic chk_state(input string tag);
        chk(int'(bw_level) == m_lvl, {tag, " level R7"}, int'(bw_level), m_lvl);
        chk(int'(lane_en) == f_mask(m_lvl), {tag, " mask R8"}, int'(lane_en), f_mask(m_lvl));
        chk(chg_stb == m_stb, {tag, " strobe R6"}, int'(chg_stb), int'(m_stb));
        if (m_stb)
            chk(int'(chg_level) == m_ann, {tag, " announced level R6"}, int'(chg_level), m_ann);
    endtask

    task automatic do_reset(input int w);
        @(negedge clk);
        rst_n = 1'b0;
        frame_start = 1'b0;
        win_frames = WW'(w);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_lvl = MAXL; m_ann = MAXL; m_cnt = 0; m_pend = 0; m_stb = 0;
        @(negedge clk);
        chk(bw_level == 2'd2, "R1 reset level", int'(bw_level), 2);
        chk(lane_en == 4'hF, "R1 reset mask", int'(lane_en), 15);
        chk(chg_stb == 1'b0, "R1 reset strobe", int'(chg_stb), 0);
    endtask

    // One frame start with queue length q, then idle cycles with junk queue values (R9, R2).
    task automatic frame(input int q, input int idle);
        int nxt;
        q_len = QW'(q);
        frame_start = 1'b1;
        m_stb = 0;
        if (m_pend) begin m_lvl = m_ann; m_pend = 0; end
        if (m_cnt >= f_weff(int'(win_frames)) - 1) begin
            m_cnt = 0;
            nxt = f_next(m_lvl, q, int'(th_lo), int'(th_hi));
            if (nxt != m_lvl) begin m_ann = nxt; m_pend = 1; m_stb = 1; end
        end else begin
            m_cnt++;
        end
        @(negedge clk);
        frame_start = 1'b0;
        chk_state("frame");
        m_stb = 0;
        for (int k = 0; k < idle; k++) begin
            q_len = QW'($urandom_range(0, 40000));
            @(negedge clk);
            chk_state("idle R9");
        end
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog R2 actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED1234));
        do_reset(3);
        // R3: three short-queue frames close a window, the fourth commits half rate.
        frame(100, 1); frame(100, 1); frame(100, 1); frame(20000, 1);
        chk(bw_level == 2'd1, "R3 halved after commit", int'(bw_level), 1);
        // Walk down to quarter rate, then hold at the limit (R5).
        for (int i = 0; i < 9; i++) frame(0, 2);
        chk(bw_level == 2'd0, "R5 floor at quarter", int'(bw_level), 0);
        // Queue exactly on each threshold holds (R5).
        for (int i = 0; i < 3; i++) frame(2500, 1);
        for (int i = 0; i < 3; i++) frame(15000, 1);
        chk(bw_level == 2'd0, "R5 equal thresholds hold", int'(bw_level), 0);
        // R4: climb to full, then hold at the ceiling.
        for (int i = 0; i < 12; i++) frame(15001, 0);
        chk(bw_level == 2'd2, "R4 ceiling at full", int'(bw_level), 2);
        // R4 priority: inverted thresholds make both conditions true.
        th_lo = QW'(9000); th_hi = QW'(1000);
        do_reset(2);
        frame(0, 1); frame(5000, 1);
        for (int i = 0; i < 4; i++) frame(5000, 1);
        chk(bw_level == 2'd2, "R4 priority over R3", int'(bw_level), 2);
        // R2: window values 0 and 1 act as 2; random stimulus on short windows.
        for (int w = 0; w < 5; w++) begin
            th_lo = QW'($urandom_range(1000, 6000));
            th_hi = QW'($urandom_range(8000, 20000));
            do_reset(w);
            for (int i = 0; i < 120; i++)
                frame($urandom_range(0, 25000), $urandom_range(1, 4));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule